// File: doc/BRIEF.md
# Twisted-Ring Divider with One-Hot Slot Outputs

This block divides its clock by an even number N and shows which of the N count positions it is in on a one-hot bus. The count is kept in a twisted-ring (Johnson) shift register of K = N/2 flip-flops. The parameter `STAGES` sets K: 5 gives a divide-by-10 with ten slot lines, 4 gives a divide-by-8 with eight. Each slot line is an AND of two neighbouring ring bits. Only one ring bit changes per advance, so the slot lines change without hazards.

The counter advances on a rising clock edge only while the active-low enable is low. A high on the asynchronous reset puts it at slot 0 at once. Reset release passes through a two-flop synchroniser, so the first advance lands on a clean edge. A square-wave carry at 1/N of the clock rate can clock a following stage, and its rising edge marks the return to slot 0. Any ring pattern outside the Johnson sequence is cleared back to slot 0 on the next clock.

Top module: `jc_counter`

## Requirements
- R1: With `STAGES` = K, `slot_o` has N = 2K lines. After slot c the next advance moves to slot (c+1) mod N, so slots come in the order 0, 1, ..., N-1, 0. This holds for K = 5 (10 slots) and K = 4 (8 slots).
- R2: While `rst_i` is 1, without waiting for a clock edge, `slot_o` equals 1 (bit 0 set, all others clear) and `carry_o` is 1.
- R3: After `rst_i` falls, the counter stays at slot 0 through the first two rising edges. The third rising edge is the first that can advance it.
- R4: In every cycle of the legal sequence exactly one `slot_o` line is high. Line i is high exactly while the count is i, which is one full clock period per enabled advance.
- R5: When `cnt_en_n_i` is 0 at a rising edge, the count advances by one.
- R6: When `cnt_en_n_i` is 1 at a rising edge, the count and all outputs keep their values.
- R7: `carry_o` is 1 for slots 0 to K-1 and 0 for slots K to N-1. It completes one high/low cycle per N advances and rises on the advance from slot N-1 to slot 0.
- R8: If the ring holds a pattern that is not a Johnson code word, the next rising edge loads slot 0, whatever the enable.
- R9: On each advance within the legal sequence exactly one ring bit changes, so exactly two `slot_o` lines change (one falls, one rises). On a held edge no line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| rst_i | input | 1 | Asynchronous reset to slot 0, active high |
| cnt_en_n_i | input | 1 | Count enable, active low; high holds the count |
| slot_o | output | 2*STAGES | One-hot decoded count |
| carry_o | output | 1 | Square wave at 1/N of the clock, for cascading |

## Verification
The hardest case to reach is a ring pattern outside the Johnson code. Reset, enable and clock only ever walk the legal N-state loop, so no sequence at the ports can produce one. The bench reaches every such pattern by forcing it onto the ring register between edges, then releasing it. It then watches the outputs return to slot 0 on the next edge, with the enable both low and high. Random enable and reset activity around this covers holds, reset release and carry wrap on both the 10-slot and the 8-slot build.

// File: rtl/jc_pkg.sv
package jc_pkg;
    // default number of ring stages (5 -> divide by 10)
    parameter int unsigned JC_STAGES_DEF = 5;
    // depth of the reset-release synchroniser
    parameter int unsigned JC_SYNC_DEPTH = 2;
endpackage

// File: rtl/jc_rst_sync.sv
module jc_rst_sync
    import jc_pkg::*;
#(
    parameter int unsigned DEPTH = JC_SYNC_DEPTH
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic rst_sync_o
);
    typedef struct packed {
        logic [DEPTH-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[DEPTH-2:0], 1'b0};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '{chain: '1};
        else       st_q <= st_d;
    end

    assign rst_sync_o = st_q.chain[DEPTH-1];
endmodule

// File: rtl/jc_ring.sv
module jc_ring #(
    parameter int unsigned STAGES = 5
) (
    input  logic              clk_i,
    input  logic              ring_rst_i,
    input  logic              adv_i,
    output logic [STAGES-1:0] ring_o
);
    typedef struct packed {
        logic [STAGES-1:0] ring;
    } ring_t;

    ring_t st_d, st_q;
    logic  legal;

    // a Johnson word has at most one boundary between neighbouring bits
    always_comb begin
        int unsigned edges;
        edges = 0;
        for (int unsigned i = 0; i + 1 < STAGES; i++) begin
            if (st_q.ring[i] != st_q.ring[i+1]) edges = edges + 1;
        end
        legal = (edges <= 1);
    end

    always_comb begin
        st_d = st_q;
        if (!legal) begin
            st_d.ring = '0;
        end else if (adv_i) begin
            st_d.ring = {st_q.ring[STAGES-2:0], ~st_q.ring[STAGES-1]};
        end
    end

    always_ff @(posedge clk_i or posedge ring_rst_i) begin
        if (ring_rst_i) st_q <= '0;
        else            st_q <= st_d;
    end

    assign ring_o = st_q.ring;
endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
    parameter int unsigned STAGES = 5,
    localparam int unsigned SLOTS = 2 * STAGES
) (
    input  logic [STAGES-1:0] ring_i,
    output logic [SLOTS-1:0]  slot_o,
    output logic              carry_o
);
    // every slot is a two-input gate on neighbouring ring bits
    assign slot_o[0]      = ~ring_i[STAGES-1] & ~ring_i[0];
    assign slot_o[STAGES] =  ring_i[STAGES-1] &  ring_i[0];

    for (genvar g = 1; g < STAGES; g++) begin : g_fill
        assign slot_o[g]          =  ring_i[g-1] & ~ring_i[g];
        assign slot_o[STAGES + g] = ~ring_i[g-1] &  ring_i[g];
    end

    assign carry_o = ~ring_i[STAGES-1];
endmodule

// File: rtl/jc_counter.sv
module jc_counter
    import jc_pkg::*;
#(
    parameter int unsigned STAGES = JC_STAGES_DEF,
    localparam int unsigned SLOTS = 2 * STAGES
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cnt_en_n_i,
    output logic [SLOTS-1:0] slot_o,
    output logic             carry_o
);
    logic              ring_rst;
    logic [STAGES-1:0] ring_q;

    jc_rst_sync #(
        .DEPTH(JC_SYNC_DEPTH)
    ) u_sync (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rst_sync_o(ring_rst)
    );

    jc_ring #(
        .STAGES(STAGES)
    ) u_ring (
        .clk_i     (clk_i),
        .ring_rst_i(ring_rst),
        .adv_i     (~cnt_en_n_i),
        .ring_o    (ring_q)
    );

    jc_decode #(
        .STAGES(STAGES)
    ) u_dec (
        .ring_i (ring_q),
        .slot_o (slot_o),
        .carry_o(carry_o)
    );
endmodule

// File: rtl/jc_counter_chk.sv
module jc_counter_chk #(
    parameter int unsigned STAGES = 5,
    localparam int unsigned SLOTS = 2 * STAGES
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              cnt_en_n_i,
    input logic              ring_rst_i,
    input logic [STAGES-1:0] ring_q,
    input logic [SLOTS-1:0]  slot_o,
    input logic              carry_o
);
    // legal words are runs of ones filled from either end
    function automatic logic is_code(input logic [STAGES-1:0] q);
        logic [STAGES-1:0] m;
        logic ok;
        ok = 1'b0;
        for (int unsigned k = 0; k <= STAGES; k++) begin
            m = '0;
            for (int unsigned b = 0; b < k; b++) m[b] = 1'b1;
            if (q == m || q == ~m) ok = 1'b1;
        end
        return ok;
    endfunction

    assert_reset_slot_R2: assert property (@(posedge clk_i)
        rst_i |-> (slot_o == SLOTS'(1) && carry_o));

    assert_onehot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        is_code(ring_q) |-> $onehot(slot_o));

    assert_advance_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cnt_en_n_i && !ring_rst_i && is_code(ring_q)) |=>
        (!is_code(ring_q) ||
         ring_q == {$past(ring_q[STAGES-2:0]), ~$past(ring_q[STAGES-1])}));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_en_n_i && is_code(ring_q)) |=>
        (!is_code(ring_q) || $stable(slot_o)));

    assert_carry_half_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        is_code(ring_q) |-> (carry_o == |slot_o[STAGES-1:0]));

    assert_recover_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !is_code(ring_q) |=> (slot_o == SLOTS'(1)));

    assert_single_bit_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_code(ring_q) && is_code($past(ring_q))) |->
        ($countones(ring_q ^ $past(ring_q)) <= 1));
endmodule

bind jc_counter jc_counter_chk #(
    .STAGES(STAGES)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cnt_en_n_i(cnt_en_n_i),
    .ring_rst_i(ring_rst),
    .ring_q    (ring_q),
    .slot_o    (slot_o),
    .carry_o   (carry_o)
);

// File: tb/jc_counter_tb_top.sv
`timescale 1ns/1ps
module jc_counter_tb_top;
    localparam int K10 = 5;
    localparam int N10 = 10;
    localparam int K8  = 4;
    localparam int N8  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_n = 1'b1;
    logic [N10-1:0] slot10;
    logic [N8-1:0]  slot8;
    logic carry10, carry8;

    int checks = 0;
    int errors = 0;
    int c10 = 0;
    int c8 = 0;
    int hold = 0;
    logic [N10-1:0] prev10;
    bit done = 0;

    always #4 clk = ~clk;

    jc_counter #(.STAGES(K10)) dut_i (
        .clk_i(clk), .rst_i(rst), .cnt_en_n_i(en_n),
        .slot_o(slot10), .carry_o(carry10));

    jc_counter #(.STAGES(K8)) dut8_i (
        .clk_i(clk), .rst_i(rst), .cnt_en_n_i(en_n),
        .slot_o(slot8), .carry_o(carry8));

    function automatic logic [15:0] hot(input int c);
        return 16'(1) << c;
    endfunction

    function automatic bit bench_legal(input logic [K10-1:0] q);
        int t = 0;
        for (int i = 0; i < K10 - 1; i++) if (q[i] != q[i+1]) t++;
        return t <= 1;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1 slot order 10"}, 16'(slot10), hot(c10));
        chk({tag, " R4 one-hot 10"}, 16'($countones(slot10)), 16'd1);
        chk({tag, " R7 carry 10"}, 16'(carry10), 16'(c10 < K10));
        chk({tag, " R1 slot order 8"}, 16'(slot8), hot(c8));
        chk({tag, " R7 carry 8"}, 16'(carry8), 16'(c8 < K8));
    endtask

    // one clock: drive at negedge, update model at posedge, check at next negedge
    task automatic step(input logic e);
        int old10;
        en_n = e;
        old10 = c10;
        @(posedge clk);
        if (hold > 0) hold--;
        else if (!e) begin
            c10 = (c10 + 1) % N10;
            c8 = (c8 + 1) % N8;
        end
        @(negedge clk);
        check_all(e ? "R6 hold" : "R5 advance");
        if (old10 != c10)
            chk("R9 two lines change", 16'($countones(slot10 ^ prev10)), 16'd2);
        else
            chk("R9 no line change", 16'($countones(slot10 ^ prev10)), 16'd0);
        prev10 = slot10;
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1 rst = 1'b1;
        #1;
        chk("R2 async slot", 16'(slot10), 16'd1);
        chk("R2 async carry", 16'(carry10), 16'd1);
        @(negedge clk);
        rst = 1'b0;
        c10 = 0;
        c8 = 0;
        hold = 2;
        prev10 = slot10;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1D2C);
        en_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 reset slot", 16'(slot10), 16'd1);
        chk("R2 reset carry", 16'(carry8), 16'd1);
        rst = 1'b0;
        hold = 2;
        prev10 = slot10;
        // R3: enable low, two edges hold, third advances
        step(1'b0);
        chk("R3 held edge 1", 16'(slot10), 16'd1);
        step(1'b0);
        chk("R3 held edge 2", 16'(slot10), 16'd1);
        step(1'b0);
        chk("R3 first advance", 16'(slot10), 16'd2);
        // directed full wrap with carry rise (R7)
        for (int i = 0; i < 2 * N10; i++) begin
            logic cprev;
            cprev = carry10;
            step(1'b0);
            if (c10 == 0) chk("R7 carry rises at slot 0", 16'({cprev, carry10}), 16'b01);
        end
        // long hold (R6)
        for (int i = 0; i < 6; i++) step(1'b1);
        // random stimulus with occasional reset
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 199) == 0) do_reset();
            step(($urandom_range(0, 9) < 3) ? 1'b1 : 1'b0);
        end
        // illegal states (R8), with enable low and high
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < (1 << K10); v++) begin
                logic [K10-1:0] vv;
                vv = K10'(v);
                if (!bench_legal(vv)) begin
                    while (hold > 0) step(1'b0);
                    force dut_i.u_ring.st_q = vv;
                    #1 release dut_i.u_ring.st_q;
                    en_n = pass[0];
                    @(posedge clk);
                    c10 = 0;
                    if (!pass[0]) c8 = (c8 + 1) % N8;
                    @(negedge clk);
                    chk("R8 recover slot", 16'(slot10), 16'd1);
                    chk("R8 recover carry", 16'(carry10), 16'd1);
                    chk("R8 other instance", 16'(slot8), hot(c8));
                    prev10 = slot10;
                    step(1'b0);
                end
            end
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule